// File: doc/BRIEF.md
# Orientation change debounce filter

This block sits between an orientation classifier and the reported orientation. The classifier presents a raw candidate code every clock. The block passes that code on as the reported orientation only after the code has stayed unchanged for a programmable number of debounce time steps. On the clock in which a new orientation is taken over, the block raises a one-clock change pulse.

Every debounce time step is a whole number of ticks of a fixed 800 Hz base sample tick. The number of ticks per step is chosen from the output data-rate code and the oversampling-mode code. Restarting the count is how the block stays consistent when the context changes. A wake/sleep transition reloads the debounce counter. A change of rate or mode restarts both the step prescaler and the debounce counter.

Top module: `orient_debounce`

## Requirements
- R1: While reset is held and directly after it, `orient_o` is 0 and `change_o` is 0.
- R2: Rate code encoding: 0=800, 1=400, 2=200, 3=100, 4=50, 5=12.5, 6=6.25, 7=1.56 Hz. Mode code encoding: 0=normal, 1=low-noise low-power, 2=high-resolution, 3=low-power. In modes 0, 1 and 3 with a rate code from 0 to 4, one step lasts 2^rate base ticks (1, 2, 4, 8, 16).
- R3: At rate codes 5 to 7, one step lasts 16 base ticks in mode 0 and 64 base ticks in mode 1. In mode 3 it lasts 64 base ticks at rate code 5 and 128 base ticks at rate codes 6 and 7.
- R4: In mode 2, one step lasts 1 base tick at rate code 0 and 2 base ticks at every other rate code.
- R5: A candidate that differs from `orient_o` and stays unchanged from a reload onward is accepted on the (N+1)-th step tick after that reload, where N is `dbnc_cnt_i` (0..255, sampled at the reload). On acceptance `orient_o` takes the candidate and `change_o` is high for exactly one clock. `orient_o` changes at no other time.
- R6: The counter reloads in any clock in which the candidate differs from its value in the previous clock, and in any clock in which the candidate equals `orient_o`. A step tick that falls in such a clock is not counted.
- R7: A change of `sleep_i`, in either direction, reloads the debounce counter. The prescaler keeps its phase.
- R8: A change of `rate_i` or `mode_i` restarts the prescaler at phase zero and reloads the debounce counter.
- R9: With N = 0, a stable new candidate is accepted on the first step tick after the reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| base_tick_i | input | 1 | One-clock pulse at the 800 Hz base sample rate |
| cand_i | input | ORIENT_W | Raw candidate orientation code |
| dbnc_cnt_i | input | DBNC_W | Debounce count N |
| rate_i | input | 3 | Output data-rate code |
| mode_i | input | 2 | Oversampling-mode code |
| sleep_i | input | 1 | 1 = sleep, 0 = wake |
| orient_o | output | ORIENT_W | Debounced orientation |
| change_o | output | 1 | One-clock pulse when `orient_o` changes |

## Verification
A step tick from the prescaler and a candidate change can fall in the same clock. In that case the change must win: the counter reloads and the tick is lost. The bench provokes this by changing the candidate in the negative half-cycle just before a base-tick edge, with a count of zero and one base tick per step. The scoreboard then expects acceptance one base tick later than it would otherwise. The same scoreboard times every other scenario by base-tick number, including sleep toggles and mode changes issued partway through a count.

// File: rtl/orient_dbnc_pkg.sv
package orient_dbnc_pkg;
  localparam int RATE_W = 3;
  localparam int MODE_W = 2;
  localparam int STEP_LOG_W = 3;
  localparam int MAX_STEP_LOG = 7;

  typedef enum logic [MODE_W-1:0] {
    OSM_NORMAL = 2'd0,
    OSM_LNLP   = 2'd1,
    OSM_HIRES  = 2'd2,
    OSM_LOWPWR = 2'd3
  } os_mode_e;

  // log2 of base ticks per debounce step
  function automatic logic [STEP_LOG_W-1:0] step_log2(input logic [RATE_W-1:0] rate,
                                                      input logic [MODE_W-1:0] mode);
    logic [STEP_LOG_W-1:0] r;
    case (os_mode_e'(mode))
      OSM_HIRES:  r = (rate == '0) ? 3'd0 : 3'd1;
      OSM_NORMAL: r = (rate <= 3'd4) ? rate : 3'd4;
      OSM_LNLP:   r = (rate <= 3'd4) ? rate : 3'd6;
      default:    r = (rate <= 3'd4) ? rate : ((rate == 3'd5) ? 3'd6 : 3'd7);
    endcase
    return r;
  endfunction
endpackage

// File: rtl/orient_ctx_watch.sv
module orient_ctx_watch
  import orient_dbnc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [RATE_W-1:0] rate_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              sleep_i,
  output logic              cfg_restart_o,
  output logic              sleep_edge_o
);
  logic [RATE_W-1:0] rate_q;
  logic [MODE_W-1:0] mode_q;
  logic              sleep_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rate_q  <= '0;
      mode_q  <= '0;
      sleep_q <= 1'b0;
    end else begin
      rate_q  <= rate_i;
      mode_q  <= mode_i;
      sleep_q <= sleep_i;
    end
  end

  assign cfg_restart_o = (rate_i != rate_q) || (mode_i != mode_q);
  assign sleep_edge_o  = sleep_i ^ sleep_q;

  assert_sleep_edge_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sleep_i != $past(sleep_i)) |-> sleep_edge_o);
endmodule

// File: rtl/orient_step_prescaler.sv
module orient_step_prescaler
  import orient_dbnc_pkg::*;
#(
  parameter int MAX_LOG = MAX_STEP_LOG
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  base_tick_i,
  input  logic                  restart_i,
  input  logic [STEP_LOG_W-1:0] log2_i,
  output logic                  step_o
);
  localparam int CNT_W = (MAX_LOG < 1) ? 1 : MAX_LOG;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   div_w;
  logic [CNT_W-1:0] last_val;
  logic             at_last;

  assign div_w    = (CNT_W+1)'(1) << log2_i;
  assign last_val = CNT_W'(div_w - 1'b1);
  assign at_last  = (cnt_q == last_val);
  assign step_o   = base_tick_i && at_last && !restart_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (restart_i)   cnt_q <= '0;
    else if (base_tick_i) cnt_q <= at_last ? '0 : cnt_q + 1'b1;
  end

  assert_cnt_in_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !restart_i |-> (cnt_q <= last_val));
  assert_step_wraps_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_o |=> (cnt_q == '0));
  assert_restart_phase_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (cnt_q == '0) && !(step_o && log2_i != '0));
endmodule

// File: rtl/orient_dbnc_core.sv
module orient_dbnc_core #(
  parameter int ORIENT_W = 3,
  parameter int DBNC_W   = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [ORIENT_W-1:0] cand_i,
  input  logic [DBNC_W-1:0]   load_i,
  input  logic                step_i,
  input  logic                reload_req_i,
  output logic [ORIENT_W-1:0] orient_o,
  output logic                change_o
);
  logic [ORIENT_W-1:0] cand_q, orient_q;
  logic [DBNC_W-1:0]   remain_q;
  logic                change_q;
  logic                reload, accept;

  // candidate must be steady and differ from the reported value to be counted
  assign reload = reload_req_i || (cand_i != cand_q) || (cand_i == orient_q);
  assign accept = !reload && step_i && (remain_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cand_q   <= '0;
      orient_q <= '0;
      remain_q <= '0;
      change_q <= 1'b0;
    end else begin
      cand_q   <= cand_i;
      change_q <= accept;
      if (accept) orient_q <= cand_i;
      if (reload)                         remain_q <= load_i;
      else if (step_i && remain_q != '0)  remain_q <= remain_q - 1'b1;
    end
  end

  assign orient_o = orient_q;
  assign change_o = change_q;

  assert_pulse_single_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    change_q |=> !change_q);
  assert_orient_with_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(orient_q) |-> change_q);
  assert_accept_on_step_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(change_q) |-> $past(step_i));
  assert_reload_value_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reload |=> (remain_q == $past(load_i)));
  assert_hold_without_step_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!reload && !step_i) |=> $stable(remain_q));
endmodule

// File: rtl/orient_debounce.sv
module orient_debounce
  import orient_dbnc_pkg::*;
#(
  parameter int ORIENT_W = 3,
  parameter int DBNC_W   = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                base_tick_i,
  input  logic [ORIENT_W-1:0] cand_i,
  input  logic [DBNC_W-1:0]   dbnc_cnt_i,
  input  logic [2:0]          rate_i,
  input  logic [1:0]          mode_i,
  input  logic                sleep_i,
  output logic [ORIENT_W-1:0] orient_o,
  output logic                change_o
);
  logic                  cfg_restart, sleep_edge, step_tick;
  logic [STEP_LOG_W-1:0] log2_sel;

  assign log2_sel = step_log2(rate_i, mode_i);

  orient_ctx_watch u_ctx (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .rate_i        (rate_i),
    .mode_i        (mode_i),
    .sleep_i       (sleep_i),
    .cfg_restart_o (cfg_restart),
    .sleep_edge_o  (sleep_edge)
  );

  orient_step_prescaler #(.MAX_LOG(MAX_STEP_LOG)) u_pre (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .base_tick_i (base_tick_i),
    .restart_i   (cfg_restart),
    .log2_i      (log2_sel),
    .step_o      (step_tick)
  );

  orient_dbnc_core #(.ORIENT_W(ORIENT_W), .DBNC_W(DBNC_W)) u_core (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cand_i       (cand_i),
    .load_i       (dbnc_cnt_i),
    .step_i       (step_tick),
    .reload_req_i (cfg_restart || sleep_edge),
    .orient_o     (orient_o),
    .change_o     (change_o)
  );

  assert_tick_gated_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(change_o) |-> $past(base_tick_i));
  assert_no_accept_on_cfg_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_restart |=> !change_o);
  assert_reset_idle_R1: assert property (@(posedge clk_i)
    !rst_ni |-> (orient_o == '0) && !change_o);
endmodule

// File: tb/orient_debounce_test.sv
module orient_debounce_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       base_tick = 1'b0;
  logic [2:0] cand = '0;
  logic [7:0] dbnc = '0;
  logic [2:0] rate = '0;
  logic [1:0] mode = '0;
  logic       sleep = 1'b0;
  logic [2:0] orient;
  logic       change;

  typedef struct {
    int    orient;
    int    tick;
    string req;
  } exp_t;

  exp_t q[$];
  int   tests = 0;
  int   fails = 0;
  int   tick_abs = 0;
  logic [1:0] ph = '0;
  bit   done = 0;

  orient_debounce uut (
    .clk_i(clk), .rst_ni(rst_n), .base_tick_i(base_tick), .cand_i(cand),
    .dbnc_cnt_i(dbnc), .rate_i(rate), .mode_i(mode), .sleep_i(sleep),
    .orient_o(orient), .change_o(change)
  );

  always #10 clk = ~clk;

  // base tick every 4 clocks, changed at negedge
  always @(negedge clk) begin
    ph        <= ph + 2'd1;
    base_tick <= (ph == 2'd3);
  end

  always @(posedge clk) if (rst_n && base_tick) tick_abs = tick_abs + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && change) begin
      if (q.size() == 0) begin
        check(0, "R5 unexpected change pulse", int'(orient), -1);
      end else begin
        exp_t e;
        e = q.pop_front();
        check(int'(orient) == e.orient, {e.req, " orientation"}, int'(orient), e.orient);
        check(tick_abs == e.tick, {e.req, " accept tick"}, tick_abs, e.tick);
      end
    end
  end

  task automatic sync_tick();
    @(posedge clk iff base_tick);
    @(negedge clk);
  endtask

  task automatic wait_ticks(input int n);
    repeat (n) @(posedge clk iff base_tick);
    @(negedge clk);
  endtask

  task automatic push(input int o, input int t, input string req);
    exp_t e;
    e.orient = o; e.tick = t; e.req = req;
    q.push_back(e);
  endtask

  // restarts prescaler in a non-tick clock, applies candidate and count together
  task automatic restart_to(input logic [2:0] r, input logic [1:0] m, input logic [2:0] c,
                            input int n, input int div, input bit do_push,
                            input string req, output int b);
    sync_tick();
    rate = r ^ 3'd1;
    @(negedge clk);
    rate = r; mode = m; cand = c; dbnc = 8'(n);
    b = tick_abs;
    if (do_push) push(int'(c), b + (n + 1) * div, req);
  endtask

  task automatic drain();
    wait (q.size() == 0);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    int b;
    repeat (5) @(negedge clk);
    check(orient == 3'd0, "R1 orient in reset", int'(orient), 0);
    check(change == 1'b0, "R1 change in reset", int'(change), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(orient == 3'd0 && change == 1'b0, "R1 after reset", int'(orient), 0);

    restart_to(3'd0, 2'd0, 3'd1, 0,   1,   1, "R9 count zero",       b); drain();
    restart_to(3'd2, 2'd0, 3'd2, 3,   4,   1, "R2 200Hz normal",     b); drain();
    restart_to(3'd5, 2'd2, 3'd3, 2,   2,   1, "R4 hires low rate",   b); drain();
    restart_to(3'd6, 2'd3, 3'd4, 1,   128, 1, "R3 lowpower 6.25Hz",  b); drain();
    restart_to(3'd7, 2'd1, 3'd5, 0,   64,  1, "R3 lnlp 1.56Hz",      b); drain();
    restart_to(3'd7, 2'd0, 3'd6, 1,   16,  1, "R3 normal 1.56Hz",    b); drain();
    restart_to(3'd0, 2'd0, 3'd7, 255, 1,   1, "R5 max count",        b); drain();

    // R7: sleep toggle part way reloads counter, prescaler phase kept
    restart_to(3'd1, 2'd0, 3'd1, 4, 2, 0, "", b);
    wait_ticks(5);
    sleep = 1'b1;
    push(1, b + 14, "R7 sleep reload");
    drain();

    // R8: mode change part way restarts prescaler and counter
    restart_to(3'd0, 2'd0, 3'd2, 3, 1, 0, "", b);
    wait_ticks(2);
    mode = 2'd2;
    push(2, b + 6, "R8 mode restart");
    drain();

    // R6: candidate returns to reported value, then new candidate again
    restart_to(3'd0, 2'd0, 3'd3, 2, 1, 0, "", b);
    wait_ticks(2);
    cand = 3'd2;
    wait_ticks(2);
    check(orient == 3'd2, "R6 return keeps orientation", int'(orient), 2);
    cand = 3'd3;
    push(3, b + 7, "R6 recount after return");
    drain();

    // R6: candidate change coincides with a step tick; tick not counted
    restart_to(3'd0, 2'd0, 3'd3, 0, 1, 0, "", b);
    @(posedge clk iff base_tick);
    repeat (4) @(negedge clk);
    cand = 3'd4;
    push(4, tick_abs + 2, "R6 change on tick");
    drain();

    check(q.size() == 0, "R5 scoreboard empty", q.size(), 0);
    check(orient == 3'd4, "R5 final orientation", int'(orient), 4);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", q.size(), 0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule